// File: doc/BRIEF.md
# Microcoded Wait Sequencer

This block is a small programmable bus sequencer. A host loads a 64-entry RAM of 32-bit control words while the block is idle. A start request then names a base index, and the sequencer runs from that word, one word per bus clock. The low bits of each word set the chip-select and general-purpose output levels for that clock. They also carry four control flags: wait-enable, acknowledge, advance-address and end-of-pattern.

An external wait input can stall the sequencer on any word that has wait-enable set. While stalled, the word index, the output levels and the wait-enable value all stay frozen. Normally the wait input passes through a two-flop synchroniser first. When a word sets both wait-enable and acknowledge, the sequencer instead samples the raw wait input on each rising edge. It completes the word, and acknowledges, at the first edge where it samples the input low. The transfer-acknowledge pulse appears in the following clock. A burst-address counter counts the words that carry the advance-address flag.

States: `S_IDLE` (outputs low, host writes accepted), `S_STEP` (first clock of a word), `S_HOLD` (word stalled by wait). Transitions:
- IDLE to STEP on start.
- STEP to HOLD on stall.
- STEP to STEP, or HOLD to STEP, when a word completes without the end flag.
- STEP to IDLE, or HOLD to IDLE, when a word completes with the end flag.

Top module: `mwseq_top`

## Requirements
- R1: Word bit 0 is the chip-select level, bit 1 the output-line level, bit 2 wait-enable, bit 3 acknowledge, bit 4 advance-address and bit 5 end-of-pattern; bits 31:6 are ignored. While a pattern runs, `cs_o` and `gpo_o` equal bits 0 and 1 of the current word; in idle both are 0.
- R2: A start request in idle selects word `base_i` as the current word in the following clock and clears `burst_addr_o` to 0.
- R3: Without a stall, each word lasts one clock, and the next word's index is one higher.
- R4: Completing a word with the end flag returns the sequencer to idle in the next clock, with `cs_o` and `gpo_o` low.
- R5: A word with wait-enable set and acknowledge clear stalls while the two-flop synchronised wait is high. Its outputs stay frozen. It completes on the third rising edge after `wait_i` is first sampled low.
- R6: `wait_i` has no effect on words whose wait-enable bit is clear.
- R7: A word with the advance-address flag increments `burst_addr_o` exactly once, in the clock after it is entered, however long it stalls.
- R8: A word with both wait-enable and acknowledge set samples `wait_i` with no synchroniser. It completes at the first rising edge that samples `wait_i` low, whether or not it was already stalled. This still holds when the end flag is also set.
- R9: `ta_o` is high for exactly the one clock after a word with the acknowledge flag completes, and never otherwise.
- R10: Host writes take effect only in idle; a write while a pattern runs leaves the RAM unchanged.
- R11: A start request while a pattern runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| base_i | input | 6 | Index of first word of the pattern |
| wr_en_i | input | 1 | Host write strobe |
| wr_idx_i | input | 6 | Host write index |
| wr_data_i | input | 32 | Host write data |
| wait_i | input | 1 | External wait input |
| cs_o | output | 1 | Chip-select level |
| gpo_o | output | 1 | General-purpose output line |
| burst_addr_o | output | 4 | Burst address counter |
| ta_o | output | 1 | Transfer-acknowledge pulse |

## Verification
The hardest case to reach from the ports is one where the stall release differs between the two wait paths. That takes a word held in a long stall while the synchroniser chain is still full of ones. The stimulus raises `wait_i` several clocks before a pattern starts, so both flops hold it. It keeps the stall for several clocks and checks that the burst address has not moved. It then drops `wait_i` one falling edge before a chosen rising edge. The asynchronous word must stay frozen for two more edges, and the synchronous word must acknowledge in the very next clock. A start and a host write issued during the stall show that both were ignored, through the word contents and the behaviour that follow.

// File: rtl/mwseq_pkg.sv
package mwseq_pkg;

    localparam int WORD_W   = 32;
    localparam int CTL_W    = 6;

    localparam int B_CS     = 0;
    localparam int B_GPO    = 1;
    localparam int B_WEN    = 2;
    localparam int B_ACK    = 3;
    localparam int B_ADV    = 4;
    localparam int B_END    = 5;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STEP = 2'd1,
        S_HOLD = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic fin;
        logic adv;
        logic ack;
        logic wen;
        logic gpo;
        logic cs;
    } ctl_t;

    function automatic ctl_t decode_word(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.cs  = w[B_CS];
        c.gpo = w[B_GPO];
        c.wen = w[B_WEN];
        c.ack = w[B_ACK];
        c.adv = w[B_ADV];
        c.fin = w[B_END];
        return c;
    endfunction

endpackage

// File: rtl/mwseq_wordram.sv
module mwseq_wordram #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic             allow_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Host port: writes land only when the sequencer reports idle.
    always_ff @(posedge clk) begin
        if (wr_en_i && allow_i) begin
            mem[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_idx_i];

endmodule

// File: rtl/mwseq_waitsync.sv
module mwseq_waitsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_i,
    output logic wait_sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], wait_i};
        end
    end

    assign wait_sync_o = chain_q[STAGES-1];

    // R5: the synchronised wait is the raw input delayed by two clocks
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (wait_sync_o == $past(wait_i, 2)));

endmodule

// File: rtl/mwseq_fsm.sv
module mwseq_fsm
    import mwseq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int BURST_W = 4,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   base_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               wait_raw_i,
    input  logic               wait_sync_i,
    output logic [IDX_W-1:0]   pc_o,
    output logic               idle_o,
    output logic               cs_o,
    output logic               gpo_o,
    output logic [BURST_W-1:0] burst_o,
    output logic               ta_o
);

    seq_state_t         state_q, state_d;
    logic [IDX_W-1:0]   pc_q, pc_d;
    logic [BURST_W-1:0] burst_q, burst_d;
    logic               ta_q, ta_d;

    ctl_t ctl;
    logic sync_mode;
    logic wait_seen;
    logic stall;
    logic unused_hi;

    assign ctl       = decode_word(word_i[CTL_W-1:0]);
    assign unused_hi = ^word_i[WORD_W-1:CTL_W];

    // Both flags set: raw wait, no synchroniser, early acknowledge.
    assign sync_mode = ctl.wen & ctl.ack;
    assign wait_seen = sync_mode ? wait_raw_i : wait_sync_i;
    assign stall     = ctl.wen & wait_seen;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        burst_d = burst_q;
        ta_d    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_STEP;
                    pc_d    = base_i;
                    burst_d = '0;
                end
            end
            S_STEP: begin
                if (ctl.adv) begin
                    burst_d = burst_q + BURST_W'(1);
                end
                if (stall) begin
                    state_d = S_HOLD;
                end else begin
                    ta_d = ctl.ack;
                    if (ctl.fin) begin
                        state_d = S_IDLE;
                    end else begin
                        pc_d = pc_q + IDX_W'(1);
                    end
                end
            end
            S_HOLD: begin
                if (!stall) begin
                    ta_d = ctl.ack;
                    if (ctl.fin) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_STEP;
                        pc_d    = pc_q + IDX_W'(1);
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (ctl.fin && (state_q != S_IDLE) && !stall) begin
            state_d = S_IDLE;
        end else if ((state_q == S_HOLD) && !stall) begin
            state_d = S_STEP;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            burst_q <= '0;
            ta_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            burst_q <= burst_d;
            ta_q    <= ta_d;
        end
    end

    // Outputs
    always_comb begin
        idle_o  = (state_q == S_IDLE);
        cs_o    = !idle_o && ctl.cs;
        gpo_o   = !idle_o && ctl.gpo;
        burst_o = burst_q;
        ta_o    = ta_q;
        pc_o    = pc_q;
    end

    // R2: start from idle selects the base word with a cleared counter
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i) |=>
            (state_q == S_STEP && pc_q == $past(base_i) && burst_q == '0));

    // R5: a held word keeps its index
    a_r5_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && $past(state_q) == S_HOLD) |-> $stable(pc_q));

    // R7: the burst counter does not move while a word stays stalled
    a_r7_burst_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && $past(state_q) == S_HOLD) |-> $stable(burst_q));

    // R9: an acknowledge pulse only follows an active clock
    a_r9_ta_source: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |-> ($past(state_q) != S_IDLE));

endmodule

// File: rtl/mwseq_top.sv
module mwseq_top
    import mwseq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int BURST_W = 4,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   base_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic               wait_i,
    output logic               cs_o,
    output logic               gpo_o,
    output logic [BURST_W-1:0] burst_addr_o,
    output logic               ta_o
);

    logic [IDX_W-1:0]  pc;
    logic [WORD_W-1:0] word;
    logic              idle;
    logic              wait_sync;

    mwseq_wordram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
        .clk      (clk),
        .wr_en_i  (wr_en_i),
        .allow_i  (idle),
        .wr_idx_i (wr_idx_i),
        .wr_data_i(wr_data_i),
        .rd_idx_i (pc),
        .rd_data_o(word)
    );

    mwseq_waitsync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_i     (wait_i),
        .wait_sync_o(wait_sync)
    );

    mwseq_fsm #(.DEPTH(DEPTH), .BURST_W(BURST_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .base_i     (base_i),
        .word_i     (word),
        .wait_raw_i (wait_i),
        .wait_sync_i(wait_sync),
        .pc_o       (pc),
        .idle_o     (idle),
        .cs_o       (cs_o),
        .gpo_o      (gpo_o),
        .burst_o    (burst_addr_o),
        .ta_o       (ta_o)
    );

endmodule

// File: tb/mwseq_top_tb_top.sv
module mwseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  base_i = '0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        wait_i = 1'b0;
    logic        cs_o, gpo_o, ta_o;
    logic [3:0]  burst_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mwseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .wait_i(wait_i), .cs_o(cs_o), .gpo_o(gpo_o),
        .burst_addr_o(burst_addr_o), .ta_o(ta_o)
    );

    function automatic logic [31:0] mk(input bit cs, input bit gpo, input bit wen,
                                       input bit ack, input bit adv, input bit fin);
        return {8'hA5, 18'h0, fin, adv, ack, wen, gpo, cs};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit cs, input bit gpo, input bit ta, input int b, input string req);
        n_cmp++;
        if (cs_o !== cs || gpo_o !== gpo || ta_o !== ta || burst_addr_o !== 4'(b)) begin
            n_bad++;
            $display("FAIL %s: got cs=%b gpo=%b ta=%b burst=%0d, expected cs=%b gpo=%b ta=%b burst=%0d",
                     req, cs_o, gpo_o, ta_o, burst_addr_o, cs, gpo, ta, b);
        end
    endtask

    task automatic host_write(input int idx, input logic [31:0] d);
        wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic go(input int base);
        start_i = 1'b1; base_i = 6'(base);
        tick();
        start_i = 1'b0;
    endtask

    // R1 R2 R3 R4 R6 R9 R10: plain pattern, wait held high on words without wait-enable
    task automatic t_plain();
        host_write(4, mk(1, 0, 0, 0, 0, 0));
        host_write(5, mk(1, 1, 0, 1, 1, 0));
        host_write(6, mk(1, 0, 0, 0, 0, 1));
        wait_i = 1'b1;
        repeat (3) tick();
        go(4);
        chk(1, 0, 0, 0, "R2 first word");
        tick(); chk(1, 1, 0, 0, "R3 R6 second word");
        tick(); chk(1, 0, 1, 1, "R9 R7 third word ack");
        tick(); chk(0, 0, 0, 1, "R4 idle after end");
    endtask

    // R5 R7 R10 R11: asynchronous stall with write and start during the hold
    task automatic t_async();
        host_write(10, mk(1, 1, 1, 0, 1, 0));
        host_write(11, mk(1, 0, 0, 1, 0, 1));
        go(10);
        chk(1, 1, 0, 0, "R1 stalled word entered");
        tick(); chk(1, 1, 0, 1, "R7 counted once on entry");
        wr_en_i = 1'b1; wr_idx_i = 6'd11; wr_data_i = mk(1, 1, 0, 0, 0, 0);
        start_i = 1'b1; base_i = 6'd4;
        tick();
        wr_en_i = 1'b0; start_i = 1'b0;
        chk(1, 1, 0, 1, "R11 start ignored in hold");
        tick(); chk(1, 1, 0, 1, "R5 frozen");
        tick(); chk(1, 1, 0, 1, "R7 no recount");
        wait_i = 1'b0;
        tick(); chk(1, 1, 0, 1, "R5 frozen after release edge 1");
        tick(); chk(1, 1, 0, 1, "R5 frozen after release edge 2");
        tick(); chk(1, 0, 0, 1, "R10 word unchanged by busy write");
        tick(); chk(0, 0, 1, 1, "R9 R4 ack then idle");
        tick(); chk(0, 0, 0, 1, "R11 R9 no restart no extra ack");
    endtask

    // R8: synchronous mode, raw release acknowledges at once
    task automatic t_sync_hold();
        host_write(20, mk(1, 0, 1, 1, 0, 0));
        host_write(21, mk(1, 1, 0, 0, 0, 1));
        wait_i = 1'b1;
        repeat (3) tick();
        go(20);
        chk(1, 0, 0, 0, "R8 sync word entered");
        tick(); chk(1, 0, 0, 0, "R8 sync stall");
        tick(); chk(1, 0, 0, 0, "R8 sync stall held");
        wait_i = 1'b0;
        tick(); chk(1, 1, 1, 0, "R8 early ack on first low sample");
        tick(); chk(0, 0, 0, 0, "R4 idle after sync pattern");
    endtask

    // R8 R7 R4: all flags in one word, wait low
    task automatic t_sync_last();
        host_write(30, mk(1, 1, 1, 1, 1, 1));
        go(30);
        chk(1, 1, 0, 0, "R8 combined word entered");
        tick(); chk(0, 0, 1, 1, "R8 R7 ack with end flag");
        tick(); chk(0, 0, 0, 1, "R9 single cycle ack");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk(0, 0, 0, 0, "R1 reset state");
        rst_n = 1'b1;
        tick();
        chk(0, 0, 0, 0, "R1 idle after reset");
        t_plain();
        t_async();
        t_sync_hold();
        t_sync_last();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule